// File: doc/BRIEF.md
# Signed Power-of-Two Coefficient Decomposer

This unit turns one fixed-point filter coefficient into a short list of shift terms so that a multiplierless filter can apply it with shifters and adders only. Each term is a sign and an exponent, and the value of the term is plus or minus two raised to that exponent. A single-cycle start pulse loads a coefficient. The unit then computes one term per clock cycle. At each step it takes the largest power of two that does not exceed the magnitude of what is still unrepresented, gives it the sign of that remainder, and subtracts it.

The coefficient is a two's complement word with `FRAC_BITS` fraction bits, so raw value 52 stands for 13.0 when `FRAC_BITS` is 2. Exponents therefore span from `-FRAC_BITS` up to a ceiling `EXP_HI`. If the remainder needs a larger power, the ceiling value is used. A mode input chooses between a two-term budget and a three-term budget. The unit stops as soon as the remainder is zero. Whatever the budget leaves unrepresented is reported as an error value in raw LSB units, together with a one-cycle done pulse.

Top module: `sopot_decomp`

## Requirements
- R1: While reset is held and after it is released, `busy` and `done` are 0, and `term_used`, `term_neg`, `term_exp` and `err_out` are all zero.
- R2: When `start` is 1 and the unit is idle, `coef_in` and `three_terms` are captured and `busy` is 1 from the next cycle on. A `start` pulse while `busy` is 1 is ignored and produces no result.
- R3: Term k covers the remainder left after terms 0..k-1. Its magnitude is the largest power of two not exceeding the remainder's magnitude, subject to R4. `term_neg[k]` is 1 when the term is subtracted, which happens exactly when the remainder is negative.
- R4: The exponent of term k is a two's complement field of EXP_W bits at `term_exp[k*EXP_W +: EXP_W]`. Its value is the bit position of that power in the raw word minus FRAC_BITS. It never exceeds EXP_HI; a larger power is replaced by 2^EXP_HI.
- R5: With `three_terms`=1 at most 3 terms are produced, and with `three_terms`=0 at most 2.
- R6: Generation stops as soon as the remainder is zero. `term_used` bits are set from bit 0 upward with no gaps. An unused term has `term_neg` 0 and exponent 0.
- R7: `err_out` (COEF_W+1 bits, signed, raw LSB units) equals the coefficient minus the sum of the produced terms. It is 0 whenever fewer terms than the budget were used.
- R8: If `start` is sampled at clock edge E and n terms are used, `done` is 1 for exactly the one cycle following edge E+n+1, and `busy` falls at that same edge.
- R9: A zero coefficient produces no terms, zero error, and `done` after edge E+1.
- R10: The result outputs keep their values from one `done` pulse until the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load `coef_in` and begin when idle |
| coef_in | input | COEF_W | Signed coefficient, FRAC_BITS fraction bits |
| three_terms | input | 1 | 1: three-term budget, 0: two-term budget |
| busy | output | 1 | Term generation in progress |
| done | output | 1 | One-cycle pulse, result valid |
| term_used | output | MAX_TERMS | Bit k set when term k is present |
| term_neg | output | MAX_TERMS | Bit k set when term k is subtracted |
| term_exp | output | MAX_TERMS*EXP_W | Packed signed exponents, term k at k*EXP_W |
| err_out | output | COEF_W+1 | Coefficient minus the approximation |

## Verification
The bench targets the places where a greedy shift encoder usually goes wrong. It drives negative coefficients, where a wrong sign choice makes the remainder grow rather than shrink. It drives values whose top power lies above the exponent ceiling, where a missing clamp gives exponents out of range and a wrong error. It drives the smallest fraction LSB, where an off-by-one floor gives an exponent of -1 instead of -2. It also covers exact powers and zero, where a unit that never stops early would spend extra cycles, set extra `term_used` bits and deliver `done` late. Each vector is run under both budgets, so a unit that ignores the mode shows up as an error or term-count mismatch. A start pulse injected while busy would, in a faulty unit, restart generation with a second coefficient or produce an extra result.

// File: rtl/sopot_pkg.sv
package sopot_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } sopot_state_e;
endpackage

// File: rtl/sopot_term_unit.sv
// Combinational: picks one signed power-of-two term from a remainder.
module sopot_term_unit #(
  parameter int RW        = 13,
  parameter int FRAC_BITS = 2,
  parameter int EXP_HI    = 6,
  parameter int EXP_W     = 4
) (
  input  logic signed [RW-1:0]    resid,
  output logic                    term_nz,
  output logic                    term_neg,
  output logic signed [EXP_W-1:0] term_exp,
  output logic signed [RW-1:0]    resid_nxt
);
  localparam logic [RW-1:0] ONE = RW'(1);

  function automatic int top_bit(input logic [RW-1:0] v);
    int p;
    p = 0;
    for (int i = 0; i < RW; i++) begin
      if (v[i]) p = i;
    end
    return p;
  endfunction

  function automatic int clamp_exp(input int e);
    return (e > EXP_HI) ? EXP_HI : e;
  endfunction

  logic [RW-1:0] mag;
  logic [RW-1:0] pw;
  int            e_cl;

  always_comb begin
    term_nz  = |resid;
    term_neg = resid[RW-1];
    mag      = term_neg ? RW'(-resid) : RW'(resid);
    e_cl     = clamp_exp(top_bit(mag) - FRAC_BITS);
    pw       = ONE << (e_cl + FRAC_BITS);
    term_exp = term_nz ? EXP_W'(e_cl) : '0;
    if (!term_nz)     resid_nxt = resid;
    else if (term_neg) resid_nxt = resid + $signed(pw);
    else               resid_nxt = resid - $signed(pw);
  end
endmodule

// File: rtl/sopot_ctrl.sv
// Sequencer: idle/run, term index, budget latch and step/finish events.
module sopot_ctrl
  import sopot_pkg::*;
#(
  parameter int MAX_TERMS = 3,
  parameter int IDX_W     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             three_terms,
  input  logic             term_nz,
  output logic             busy,
  output logic             load_evt,
  output logic             step_evt,
  output logic             finish_evt,
  output logic [IDX_W-1:0] idx,
  output logic             cfg_three
);
  sopot_state_e state;
  logic         at_limit;

  always_comb begin
    at_limit   = idx == (cfg_three ? IDX_W'(MAX_TERMS) : IDX_W'(MAX_TERMS - 1));
    load_evt   = (state == ST_IDLE) && start;
    finish_evt = (state == ST_RUN) && (at_limit || !term_nz);
    step_evt   = (state == ST_RUN) && !finish_evt;
    busy       = state == ST_RUN;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      idx       <= '0;
      cfg_three <= 1'b0;
    end else if (load_evt) begin
      state     <= ST_RUN;
      idx       <= '0;
      cfg_three <= three_terms;
    end else if (finish_evt) begin
      state <= ST_IDLE;
    end else if (step_evt) begin
      idx <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/sopot_decomp.sv
module sopot_decomp #(
  parameter int COEF_W    = 12,
  parameter int FRAC_BITS = 2,
  parameter int EXP_HI    = 6,
  parameter int MAX_TERMS = 3,
  localparam int RW       = COEF_W + 1,
  localparam int EXP_MAG  = (EXP_HI > FRAC_BITS) ? EXP_HI : FRAC_BITS,
  localparam int EXP_W    = $clog2(EXP_MAG + 1) + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic signed [COEF_W-1:0]   coef_in,
  input  logic                       three_terms,
  output logic                       busy,
  output logic                       done,
  output logic [MAX_TERMS-1:0]       term_used,
  output logic [MAX_TERMS-1:0]       term_neg,
  output logic [MAX_TERMS*EXP_W-1:0] term_exp,
  output logic signed [RW-1:0]       err_out
);
  localparam int IDX_W = $clog2(MAX_TERMS + 1);

  // named internal events, observed by the bound checker
  logic             load_evt, step_evt, finish_evt, term_nz, cfg_three;
  logic [IDX_W-1:0] idx;

  logic signed [RW-1:0]    resid, resid_nxt;
  logic                    cur_neg;
  logic signed [EXP_W-1:0] cur_exp;

  logic [MAX_TERMS-1:0]    used_wk, neg_wk;
  logic signed [EXP_W-1:0] exp_wk  [MAX_TERMS];
  logic signed [EXP_W-1:0] exp_out [MAX_TERMS];

  sopot_ctrl #(.MAX_TERMS(MAX_TERMS), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .three_terms(three_terms),
    .term_nz(term_nz), .busy(busy), .load_evt(load_evt), .step_evt(step_evt),
    .finish_evt(finish_evt), .idx(idx), .cfg_three(cfg_three)
  );

  sopot_term_unit #(.RW(RW), .FRAC_BITS(FRAC_BITS), .EXP_HI(EXP_HI), .EXP_W(EXP_W)) u_term (
    .resid(resid), .term_nz(term_nz), .term_neg(cur_neg),
    .term_exp(cur_exp), .resid_nxt(resid_nxt)
  );

  // working state: remainder and terms collected so far
  always_ff @(posedge clk) begin
    if (!rst_n || load_evt) begin
      resid   <= rst_n ? RW'(coef_in) : '0;
      used_wk <= '0;
      neg_wk  <= '0;
      for (int k = 0; k < MAX_TERMS; k++) exp_wk[k] <= '0;
    end else if (step_evt) begin
      resid        <= resid_nxt;
      used_wk[idx] <= 1'b1;
      neg_wk[idx]  <= cur_neg;
      exp_wk[idx]  <= cur_exp;
    end
  end

  // result registers, written only when a coefficient completes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done      <= 1'b0;
      term_used <= '0;
      term_neg  <= '0;
      err_out   <= '0;
      for (int k = 0; k < MAX_TERMS; k++) exp_out[k] <= '0;
    end else begin
      done <= finish_evt;
      if (finish_evt) begin
        term_used <= used_wk;
        term_neg  <= neg_wk;
        err_out   <= resid;
        for (int k = 0; k < MAX_TERMS; k++) exp_out[k] <= exp_wk[k];
      end
    end
  end

  for (genvar g = 0; g < MAX_TERMS; g++) begin : g_pack
    assign term_exp[g*EXP_W +: EXP_W] = exp_out[g];
  end
endmodule

// File: rtl/sopot_decomp_chk.sv
module sopot_decomp_chk #(
  parameter int MAX_TERMS = 3,
  parameter int EXP_W     = 4,
  parameter int RW        = 13,
  parameter int FRAC_BITS = 2,
  parameter int EXP_HI    = 6
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       start,
  input logic                       busy,
  input logic                       done,
  input logic                       cfg_three,
  input logic [MAX_TERMS-1:0]       term_used,
  input logic [MAX_TERMS-1:0]       term_neg,
  input logic [MAX_TERMS*EXP_W-1:0] term_exp,
  input logic signed [RW-1:0]       err_out
);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_ends_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  assert_busy_from_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  assert_used_contig_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((term_used & MAX_TERMS'(term_used + 1'b1)) == '0));

  assert_budget_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cfg_three || !term_used[MAX_TERMS-1]));

  assert_exact_on_early_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (!term_used[MAX_TERMS-2] || (cfg_three && !term_used[MAX_TERMS-1])))
      |-> (err_out == '0));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(err_out) && $stable(term_used) && $stable(term_exp)));

  for (genvar k = 0; k < MAX_TERMS; k++) begin : g_term
    assert_exp_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && term_used[k]) |->
        ($signed(term_exp[k*EXP_W +: EXP_W]) <= EXP_HI &&
         $signed(term_exp[k*EXP_W +: EXP_W]) >= -FRAC_BITS));
    assert_unused_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !term_used[k]) |->
        (!term_neg[k] && term_exp[k*EXP_W +: EXP_W] == '0));
  end
endmodule

bind sopot_decomp sopot_decomp_chk #(
  .MAX_TERMS(MAX_TERMS), .EXP_W(EXP_W), .RW(RW),
  .FRAC_BITS(FRAC_BITS), .EXP_HI(EXP_HI)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .cfg_three(cfg_three), .term_used(term_used), .term_neg(term_neg),
  .term_exp(term_exp), .err_out(err_out)
);

// File: tb/sopot_decomp_tb.sv
module sopot_decomp_tb;
  localparam int CLK_PERIOD = 10;
  localparam int COEF_W     = 12;
  localparam int FRAC_BITS  = 2;
  localparam int EXP_HI     = 6;
  localparam int MAX_TERMS  = 3;
  localparam int RW         = COEF_W + 1;
  localparam int EXP_W      = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic signed [COEF_W-1:0] coef_in = '0;
  logic three_terms = 1'b0;
  logic busy, done;
  logic [MAX_TERMS-1:0] term_used, term_neg;
  logic [MAX_TERMS*EXP_W-1:0] term_exp;
  logic signed [RW-1:0] err_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  sopot_decomp #(.COEF_W(COEF_W), .FRAC_BITS(FRAC_BITS), .EXP_HI(EXP_HI),
                 .MAX_TERMS(MAX_TERMS)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .coef_in(coef_in),
    .three_terms(three_terms), .busy(busy), .done(done), .term_used(term_used),
    .term_neg(term_neg), .term_exp(term_exp), .err_out(err_out)
  );

  typedef struct {
    int   coef;
    logic [MAX_TERMS-1:0] used;
    logic [MAX_TERMS-1:0] neg;
    int   ex [MAX_TERMS];
    int   err;
    int   n;
    int   due;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  int   cyc    = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // reference: walk exponents down from the ceiling until the power fits
  function automatic exp_t model(input int coef, input bit three);
    exp_t e;
    int   r, mag, k, lim;
    e.coef = coef; e.used = '0; e.neg = '0; e.n = 0;
    for (int i = 0; i < MAX_TERMS; i++) e.ex[i] = 0;
    r   = coef;
    lim = three ? 3 : 2;
    for (int i = 0; i < lim; i++) begin
      if (r == 0) break;
      mag = (r < 0) ? -r : r;
      k = EXP_HI;
      while (k > -FRAC_BITS && (1 << (k + FRAC_BITS)) > mag) k--;
      e.used[i] = 1'b1;
      e.neg[i]  = (r < 0);
      e.ex[i]   = k;
      r = (r < 0) ? r + (1 << (k + FRAC_BITS)) : r - (1 << (k + FRAC_BITS));
      e.n++;
    end
    e.err = r;
    return e;
  endfunction

  // monitor: every done pulse must match the next queued expectation
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        if (q.size() == 0) begin
          chk(1'b0, "R2 unexpected result", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(cyc == e.due, "R8 done timing", cyc, e.due);
          chk(term_used == e.used, "R5/R6 term_used", int'(term_used), int'(e.used));
          chk(term_neg == e.neg, "R3 term_neg", int'(term_neg), int'(e.neg));
          for (int k = 0; k < MAX_TERMS; k++)
            chk($signed(term_exp[k*EXP_W +: EXP_W]) == e.ex[k], "R4 exponent",
                int'($signed(term_exp[k*EXP_W +: EXP_W])), e.ex[k]);
          chk(int'(err_out) == e.err, "R7 error", int'(err_out), e.err);
        end
      end
    end
  end

  // driver: push expectation, pulse start, optionally poke start while busy
  task automatic run(input int coef, input bit three, input bit poke);
    exp_t e;
    e = model(coef, three);
    @(negedge clk);
    start = 1'b1; coef_in = COEF_W'(coef); three_terms = three;
    @(negedge clk);
    e.due = cyc + e.n + 1;
    q.push_back(e);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    if (poke) begin
      start = 1'b1; coef_in = COEF_W'(52); three_terms = ~three;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(term_used == e.used, "R10 hold term_used", int'(term_used), int'(e.used));
    chk(int'(err_out) == e.err, "R10 hold error", int'(err_out), e.err);
    chk(busy == 1'b0, "R2 idle after done", int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0, "R1 reset flags", int'({busy, done}), 0);
    chk(term_used == 0 && term_neg == 0 && term_exp == 0, "R1 reset terms",
        int'(term_used), 0);
    chk(err_out == 0, "R1 reset error", int'(err_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && done == 0, "R1 after release", int'({busy, done}), 0);

    for (int m = 0; m < 2; m++) begin
      run(52, m[0], 0);     // 13.0: R3 greedy, R5 budget
      run(100, m[0], 0);    // 25.0
      run(268, m[0], 0);    // 67.0
      run(-52, m[0], 0);    // R3 negative remainder
      run(-301, m[0], 0);
      run(64, m[0], 0);     // R6 single power, early stop
      run(1, m[0], 0);      // R4 exponent floor
      run(3, m[0], 0);
      run(2000, m[0], 0);   // R4 ceiling clamp
      run(-2048, m[0], 0);  // R4 clamp, most negative
      run(2047, m[0], 0);
      run(0, m[0], 0);      // R9 zero input
    end
    run(1500, 1'b1, 1);     // R2 start while busy ignored
    run(0, 1'b0, 1);        // R9 then R2 poke after finish window

    repeat (5) @(negedge clk);
    chk(q.size() == 0, "R8 missing results", q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule